// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt causes of a 16550-style serial port and presents the most urgent enabled one through a read-only 8-bit identification value and one interrupt request line. The causes are line errors, received data reaching its level, a character timeout, a transmit refill request and a modem status change. Each cause has its own pending flag, and each flag has its own set event and its own clear condition.

The receive data path, the FIFOs, the baud generator and the host bus are outside the block. They appear only as level inputs, event pulses and read or write strobes. A host reads the identification value and services the reported cause. The access that services a cause also clears it, and the next cause then shows up.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is applied and after it is released, the identification value reads 8'h01 and the request line is low.
- R2: Bit 0 is an active-low pending flag. It is 0 whenever at least one enabled source is pending and 1 otherwise. Bits 3:1 carry the code of the reported source: 3'b011 for a line error, 3'b010 for received data, 3'b110 for a character timeout, 3'b001 for a transmit request and 3'b000 for a modem change.
- R3: The source reported is the first enabled pending one in this order: line error, received data, character timeout, transmit request, modem change. When bit 3 is 1, bits 2:1 read 2'b10.
- R4: Any bit of `err_evt` sets the line-error flag at the next clock edge. A cycle with `rd_lsr` clears the flag. An error that arrives in the same cycle as the read keeps the flag set.
- R5: When `fifo_on` is 0, the received-data flag takes the value of `rx_full` at each clock edge. A read of the receive buffer that drops `rx_full` therefore removes it.
- R6: When `fifo_on` is 1, the received-data flag takes the value of `rx_at_trig` at each clock edge. The exception is a cycle with `rx_flush`, which forces the flag to 0.
- R7: A `rx_tmo` pulse sets the timeout flag only while `fifo_on` is 1. A cycle with `rd_rbr` or `rx_flush` clears the flag, and that clear wins over a timeout pulse in the same cycle. The flag also clears whenever `fifo_on` is 0.
- R8: A `tx_req` pulse sets the transmit flag. A cycle with `wr_thr` clears it. A cycle with `rd_iir` clears it only when the identification value shown in that cycle reports the transmit request.
- R9: A `ms_chg` pulse sets the modem flag and a cycle with `rd_msr` clears it. A pulse in the same cycle as the read keeps the flag set.
- R10: The enable bits are `ien[0]` for received data and timeout, `ien[1]` for transmit, `ien[2]` for line error and `ien[3]` for modem. A disabled source is left out of the identification value but stays pending. It is reported as soon as its enable bit is set again.
- R11: `irq` is high exactly when `gie` is 1 and bit 0 of the identification value is 0. With `gie` at 0, the identification value still reports the source.
- R12: The identification value in a cycle reflects the flags as they stood at the previous clock edge. A source that arrives during an identification read is not visible in that read. The transmit clear on that read follows the value that was shown.
- R13: Bits 7:6 both show the FIFO mode as it was registered at the previous clock edge. Bits 5:4 are always 0, and bits 7:4 are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | FIFO mode enabled |
| err_evt | input | ERR_W | Line error events: overrun, parity, framing, break |
| rx_full | input | 1 | Receive holding buffer full (non-FIFO mode) |
| rx_at_trig | input | 1 | Receive FIFO level at or above the trigger threshold |
| rx_tmo | input | 1 | Character timeout event |
| tx_req | input | 1 | Transmit FIFO requests data |
| ms_chg | input | 1 | Modem status inputs changed |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer or FIFO read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| rx_flush | input | 1 | Receive FIFO reset strobe |
| ien | input | 4 | Per-source enables |
| gie | input | 1 | Global interrupt enable |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an identification read that lands in the same cycle as a higher-priority event. There, the transmit flag must clear because of the value the reader saw, not because of the state that follows the read. The stimulus gets there by leaving the transmit request as the only pending cause. It then drives `rd_iir` together with a line error pulse. The bench checks that the value shown during the read still reports the transmit code. It also checks that, once the line status is read, nothing is left pending. The same kind of step also covers the clears that lose to sets in the same cycle: the timeout clear beats a timeout pulse, while a line error or modem pulse beats its own read.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic [ERR_W-1:0] err_evt,
  input  logic             rx_full,
  input  logic             rx_at_trig,
  input  logic             rx_tmo,
  input  logic             tx_req,
  input  logic             ms_chg,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  input  logic             rx_flush,
  input  logic [3:0]       ien,
  input  logic             gie,
  output logic [7:0]       iir,
  output logic             irq
);

  localparam logic [2:0] CODE_LINE = 3'b011;
  localparam logic [2:0] CODE_RXD  = 3'b010;
  localparam logic [2:0] CODE_TMO  = 3'b110;
  localparam logic [2:0] CODE_TX   = 3'b001;
  localparam logic [2:0] CODE_MS   = 3'b000;

  logic line_p, rxd_p, tmo_p, tx_p, ms_p, mode_q;
  logic [2:0] code;
  logic       none;

  wire tx_shown = rd_iir && (iir[3:0] == {CODE_TX, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= 1'b0;
      rxd_p  <= 1'b0;
      tmo_p  <= 1'b0;
      tx_p   <= 1'b0;
      ms_p   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= fifo_on;
      line_p <= (|err_evt) | (line_p & ~rd_lsr);
      rxd_p  <= (fifo_on ? rx_at_trig : rx_full) & ~(fifo_on & rx_flush);
      tmo_p  <= fifo_on & ~rd_rbr & ~rx_flush & (rx_tmo | tmo_p);
      tx_p   <= tx_req | (tx_p & ~wr_thr & ~tx_shown);
      ms_p   <= ms_chg | (ms_p & ~rd_msr);
    end
  end

  always_comb begin
    none = 1'b0;
    code = CODE_MS;
    if      (line_p & ien[2]) code = CODE_LINE;
    else if (rxd_p  & ien[0]) code = CODE_RXD;
    else if (tmo_p  & ien[0]) code = CODE_TMO;
    else if (tx_p   & ien[1]) code = CODE_TX;
    else if (ms_p   & ien[3]) code = CODE_MS;
    else                      none = 1'b1;
  end

  assign iir = {mode_q, mode_q, 2'b00, code, none};
  assign irq = gie & ~iir[0];

  assert_line_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> line_p);

  assert_line_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !(|err_evt)) |=> !line_p);

  assert_tmo_fifo_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on || rx_flush) |=> !tmo_p);

  assert_tx_write_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !tx_req) |=> !tx_p);

  assert_ms_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ms_chg |=> ms_p);

  assert_tmo_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iir[3] |-> (iir[2:1] == 2'b10));

  assert_snapshot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir[3:0] == 4'b0010 && !tx_req) |=> !tx_p);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_on = 1'b0, rx_full = 1'b0, rx_at_trig = 1'b0, rx_tmo = 1'b0;
  logic tx_req = 1'b0, ms_chg = 1'b0;
  logic rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, rd_msr = 1'b0;
  logic wr_thr = 1'b0, rx_flush = 1'b0, gie = 1'b0;
  logic [3:0] err_evt = 4'd0;
  logic [3:0] ien = 4'd0;
  logic [7:0] iir;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .err_evt(err_evt),
    .rx_full(rx_full), .rx_at_trig(rx_at_trig), .rx_tmo(rx_tmo),
    .tx_req(tx_req), .ms_chg(ms_chg), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_iir(rd_iir), .rd_msr(rd_msr), .wr_thr(wr_thr), .rx_flush(rx_flush),
    .ien(ien), .gie(gie), .iir(iir), .irq(irq)
  );

  // stimulus bits: [17] gie [16:13] ien [12] fifo_on [11] rx_full [10] rx_at_trig
  // [9] err [8] tmo [7] tx_req [6] ms_chg [5] rd_lsr [4] rd_rbr [3] rd_iir
  // [2] rd_msr [1] wr_thr [0] rx_flush ; then expected iir, irq, requirement
  localparam int NV = 42;
  localparam logic [30:0] VEC [NV] = '{
    {18'b1_1111_0_00_0000_0000_00, 8'h01, 1'b0, 4'd2},   // R2 idle
    {18'b1_1111_0_00_0001_0000_00, 8'h00, 1'b1, 4'd9},   // R9 modem set
    {18'b1_1111_0_00_0010_0000_00, 8'h02, 1'b1, 4'd3},   // R3 tx over modem
    {18'b1_1111_0_10_0000_0000_00, 8'h04, 1'b1, 4'd5},   // R5 buffer full
    {18'b1_1111_0_10_1000_0000_00, 8'h06, 1'b1, 4'd3},   // R3 line on top
    {18'b1_1111_0_10_0000_1000_00, 8'h04, 1'b1, 4'd4},   // R4 lsr read
    {18'b1_1111_0_00_0000_0100_00, 8'h02, 1'b1, 4'd5},   // R5 buffer read
    {18'b1_1111_0_00_0000_0010_00, 8'h00, 1'b1, 4'd8},   // R8 iir read clears tx
    {18'b1_1111_0_00_0000_0001_00, 8'h01, 1'b0, 4'd9},   // R9 msr read
    {18'b1_1111_1_00_0100_0000_00, 8'hCC, 1'b1, 4'd7},   // R7 timeout
    {18'b1_1111_1_01_0000_0000_00, 8'hC4, 1'b1, 4'd3},   // R3 data over timeout
    {18'b1_1111_1_00_0000_0100_00, 8'hC1, 1'b0, 4'd6},   // R6 below threshold
    {18'b1_1111_1_00_0100_0100_00, 8'hC1, 1'b0, 4'd7},   // R7 clear wins
    {18'b1_1111_1_01_0000_0000_01, 8'hC1, 1'b0, 4'd6},   // R6 flush
    {18'b1_1111_1_01_0000_0000_00, 8'hC4, 1'b1, 4'd6},   // R6 threshold
    {18'b1_1111_1_01_0100_0000_00, 8'hC4, 1'b1, 4'd3},   // R3 data and timeout
    {18'b1_1111_1_00_0000_0000_01, 8'hC1, 1'b0, 4'd7},   // R7 flush clears
    {18'b1_1111_0_00_0100_0000_00, 8'h01, 1'b0, 4'd7},   // R7 no timeout w/o fifo
    {18'b1_1111_1_00_0100_0000_00, 8'hCC, 1'b1, 4'd13},  // R13 mode bits
    {18'b1_1111_0_00_0000_0000_00, 8'h01, 1'b0, 4'd7},   // R7 fifo off clears
    {18'b1_1101_0_00_0010_0000_00, 8'h01, 1'b0, 4'd10},  // R10 tx masked
    {18'b1_1111_0_00_0000_0000_00, 8'h02, 1'b1, 4'd10},  // R10 unmasked
    {18'b0_1111_0_00_0000_0000_00, 8'h02, 1'b0, 4'd11},  // R11 global off
    {18'b1_1111_0_00_1000_0010_00, 8'h06, 1'b1, 4'd12},  // R12 read with new error
    {18'b1_1111_0_00_0000_1000_00, 8'h01, 1'b0, 4'd12},  // R12 tx was cleared
    {18'b1_1111_0_00_1000_0000_00, 8'h06, 1'b1, 4'd4},   // R4 set
    {18'b1_1111_0_00_1000_1000_00, 8'h06, 1'b1, 4'd4},   // R4 set beats read
    {18'b1_1111_0_00_0000_1000_00, 8'h01, 1'b0, 4'd4},   // R4 clear
    {18'b1_1111_0_00_0011_0000_00, 8'h02, 1'b1, 4'd3},   // R3 tx over modem
    {18'b1_1111_0_00_0000_0000_10, 8'h00, 1'b1, 4'd8},   // R8 write clears
    {18'b1_1111_0_00_0001_0001_00, 8'h00, 1'b1, 4'd9},   // R9 set beats read
    {18'b1_1111_0_00_0000_0001_00, 8'h01, 1'b0, 4'd9},   // R9 clear
    {18'b1_1111_0_00_1010_0000_00, 8'h06, 1'b1, 4'd3},   // R3 line over tx
    {18'b1_1111_0_00_0000_0010_00, 8'h06, 1'b1, 4'd8},   // R8 read while line shown
    {18'b1_1111_0_00_0000_1000_00, 8'h02, 1'b1, 4'd8},   // R8 tx kept
    {18'b1_1111_0_00_0000_0000_10, 8'h01, 1'b0, 4'd8},   // R8 write clears
    {18'b1_1011_0_00_1000_0000_00, 8'h01, 1'b0, 4'd10},  // R10 line masked
    {18'b1_1111_0_00_0000_0000_00, 8'h06, 1'b1, 4'd10},  // R10 line unmasked
    {18'b1_1111_0_00_0000_1000_00, 8'h01, 1'b0, 4'd4},   // R4 clear
    {18'b1_0000_0_00_0001_0000_00, 8'h01, 1'b0, 4'd10},  // R10 all masked
    {18'b1_1000_0_00_0000_0000_00, 8'h00, 1'b1, 4'd10},  // R10 modem only
    {18'b1_1111_0_00_0000_0001_00, 8'h01, 1'b0, 4'd9}    // R9 clear
  };

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: iir/irq actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0] s, input int idx);
    gie = s[17]; ien = s[16:13]; fifo_on = s[12]; rx_full = s[11];
    rx_at_trig = s[10]; err_evt = s[9] ? (4'b0001 << (idx % 4)) : 4'd0;
    rx_tmo = s[8]; tx_req = s[7]; ms_chg = s[6]; rd_lsr = s[5]; rd_rbr = s[4];
    rd_iir = s[3]; rd_msr = s[2]; wr_thr = s[1]; rx_flush = s[0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1 in reset", {iir, irq}, {8'h01, 1'b0});
    @(negedge clk); rst_n = 1'b1; gie = 1'b1; ien = 4'hF;
    @(negedge clk);
    check("R1 after reset", {iir, irq}, {8'h01, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:13], i);
      @(negedge clk);
      check($sformatf("R%0d step %0d", VEC[i][3:0], i), {iir, irq}, VEC[i][12:4]);
    end
    apply(18'b1_1111_0_00_0000_0000_00, 0);

    // R12: value shown during the read cycle ignores a same-cycle line error
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
    rd_iir = 1'b1; err_evt = 4'b0100; #1;
    check("R12 shown during read", {iir, irq}, {8'h02, 1'b1});
    @(negedge clk); rd_iir = 1'b0; err_evt = 4'd0;
    check("R12 after read", {iir, irq}, {8'h06, 1'b1});
    rd_lsr = 1'b1; @(negedge clk); rd_lsr = 1'b0;
    check("R12 nothing left", {iir, irq}, {8'h01, 1'b0});

    // R13: mode bits follow one edge later, bits 5:4 stay zero
    fifo_on = 1'b1; #1;
    check("R13 before edge", {iir, irq}, {8'h01, 1'b0});
    @(negedge clk);
    check("R13 after edge", {iir, irq}, {8'hC1, 1'b0});

    // R1: reset in the middle of activity
    ms_chg = 1'b1; rx_tmo = 1'b1; @(negedge clk); ms_chg = 1'b0; rx_tmo = 1'b0;
    check("R2 timeout pending", {iir, irq}, {8'hCC, 1'b1});
    rst_n = 1'b0; #1;
    check("R1 mid-run reset", {iir, irq}, {8'h01, 1'b0});
    @(negedge clk); rst_n = 1'b1; fifo_on = 1'b0;
    @(negedge clk);
    check("R1 flags cleared", {iir, irq}, {8'h01, 1'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule